// File: doc/BRIEF.md
# Two-Level Prioritized Interrupt Controller

This block gathers fifteen interrupt inputs, numbered 1 to 15, for a single processor and presents the processor with one 4-bit interrupt number. A rising edge on an input is recorded in a pending vector. If the line's broadcast bit is set, the edge is recorded in a software force vector instead. Software may also set and clear force bits directly. A mask selects which lines may be served. A per-line level bit places each line in a high or a low group. Lines in the high group always win over lines in the low group. Within the group being served, the highest-numbered line wins.

Software reaches the block through a word-only register port with an 8-bit byte offset. The processor retires a request by presenting its number on the acknowledge port, which removes that line from both the pending and the force vectors. A line number of 0 does not exist. Bit 0 of every vector is therefore always zero.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, every register reads zero and `irqNum` is 0.
- R2: A 0-to-1 change on `irqIn[n]` (n = 1..15) whose broadcast bit is clear sets pending bit n on the next clock edge. Holding the input high or dropping it has no effect on the registers.
- R3: A 0-to-1 change on `irqIn[n]` whose broadcast bit (offset 0x14, bit n) is set sets force bit n and leaves pending bit n unchanged.
- R4: The eligible set is (pending OR force) AND mask (offset 0x40). `irqNum` is the highest-numbered eligible line, or 0 when nothing is eligible.
- R5: Eligible lines whose level bit (offset 0x00, bit n) is 1 form the high group. When the high group is not empty, `irqNum` is the highest line in the high group, even if a higher-numbered line is eligible in the low group.
- R6: A write to offset 0x08 replaces the force vector with bits 15:1 of the data. A write to offset 0x80 computes force = (force OR data[15:1]) AND NOT data[31:17], in which data bit 16+n clears line n. Both offsets read back the force vector.
- R7: A write to offset 0x0C removes the written bits 15:1 from both the pending and the force vectors. Offset 0x0C reads as zero.
- R8: When `ackValid` is high, the line given by `ackNum` is removed from the pending and force vectors on the next clock edge. `ackNum` = 0 changes nothing.
- R9: Writes to offset 0x04 (pending, read-only) and offset 0x10 (status) have no effect. Offset 0x10, unmapped offsets, and offsets with `busAddr[1:0]` not equal to 0 read as zero.
- R10: Data bit 0 is discarded on writes to the level, force, clear, mask and broadcast registers, so bit 0 always reads back as 0.
- R11: If a new rising edge on a line arrives in the same cycle as an acknowledge of that line, or as a clear write for that line, the line stays set.
- R12: The level (0x00), mask (0x40) and broadcast (0x14) registers read back bits 15:1 exactly as written, with bits 31:16 reading zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irqIn | input | 16 | Interrupt inputs; bit n is line n, bit 0 unused |
| busSel | input | 1 | Register access strobe, one cycle per access |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | 8 | Byte offset of the register |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, combinational from the offset |
| ackValid | input | 1 | Acknowledge strobe |
| ackNum | input | 4 | Line number being acknowledged |
| irqNum | output | 4 | Line number requested from the processor, 0 = none |

## Verification
The output number is checked with a single pending line, with two lines at once, and again after the lower line is removed. These cases separate highest-line-wins from first-come or lowest-line selection. The same pair is then retried with the level bit set on the lower line, which shows whether the group rule overrides line order. Masking is checked separately from pending, which shows that masking only gates eligibility and does not discard requests. Each of the three entry paths is exercised on its own: the pending path, the broadcast path into force, and direct force writes. Same-cycle collisions between a new edge and an acknowledge or clear then show which side wins.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
  localparam int LINES     = 15;
  localparam int VEC_W     = LINES + 1;
  localparam int NUM_W     = $clog2(VEC_W);
  localparam int DATA_W    = 32;
  localparam int ADDR_W    = 8;
  localparam int CLR_SHIFT = 16;

  localparam logic [ADDR_W-1:0] OFF_LEVEL  = 8'h00;
  localparam logic [ADDR_W-1:0] OFF_PEND   = 8'h04;
  localparam logic [ADDR_W-1:0] OFF_FORCE  = 8'h08;
  localparam logic [ADDR_W-1:0] OFF_CLEAR  = 8'h0C;
  localparam logic [ADDR_W-1:0] OFF_STATUS = 8'h10;
  localparam logic [ADDR_W-1:0] OFF_BCAST  = 8'h14;
  localparam logic [ADDR_W-1:0] OFF_MASK   = 8'h40;
  localparam logic [ADDR_W-1:0] OFF_FMOD   = 8'h80;

  localparam logic [VEC_W-1:0] LINE_MASK = {{LINES{1'b1}}, 1'b0};

  typedef enum logic [2:0] {
    RD_ZERO, RD_LEVEL, RD_PEND, RD_FORCE, RD_BCAST, RD_MASK
  } rdSelT;

  typedef struct packed {
    logic             wrLevel;
    logic             wrForce;
    logic             wrForceMod;
    logic             wrClear;
    logic             wrBcast;
    logic             wrMask;
    logic [VEC_W-1:0] ackVec;
    rdSelT            rdSel;
  } strobeT;
endpackage

// File: rtl/prio_irq_ctrl_ctl.sv
module prio_irq_ctrl_ctl
  import prio_irq_pkg::*;
(
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              ackValid,
  input  logic [NUM_W-1:0]  ackNum,
  output strobeT            stb
);
  logic aligned;
  logic doWr;
  logic doRd;
  logic [VEC_W-1:0] ackOneHot;

  assign aligned = (busAddr[1:0] == 2'b00);
  assign doWr    = busSel && busWr && aligned;
  assign doRd    = busSel && !busWr && aligned;

  // one-hot acknowledge; line 0 does not exist
  for (genvar g = 0; g < VEC_W; g++) begin : gAck
    if (g == 0) begin : gNone
      assign ackOneHot[g] = 1'b0;
    end else begin : gLine
      assign ackOneHot[g] = ackValid && (ackNum == NUM_W'(g));
    end
  end

  always_comb begin
    stb            = '0;
    stb.rdSel      = RD_ZERO;
    stb.ackVec     = ackOneHot;
    stb.wrLevel    = doWr && (busAddr == OFF_LEVEL);
    stb.wrForce    = doWr && (busAddr == OFF_FORCE);
    stb.wrForceMod = doWr && (busAddr == OFF_FMOD);
    stb.wrClear    = doWr && (busAddr == OFF_CLEAR);
    stb.wrBcast    = doWr && (busAddr == OFF_BCAST);
    stb.wrMask     = doWr && (busAddr == OFF_MASK);
    if (doRd) begin
      case (busAddr)
        OFF_LEVEL: stb.rdSel = RD_LEVEL;
        OFF_PEND:  stb.rdSel = RD_PEND;
        OFF_FORCE: stb.rdSel = RD_FORCE;
        OFF_FMOD:  stb.rdSel = RD_FORCE;
        OFF_BCAST: stb.rdSel = RD_BCAST;
        OFF_MASK:  stb.rdSel = RD_MASK;
        default:   stb.rdSel = RD_ZERO;
      endcase
    end
  end
endmodule

// File: rtl/prio_irq_ctrl_dp.sv
module prio_irq_ctrl_dp
  import prio_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [VEC_W-1:0]  irqIn,
  input  logic [DATA_W-1:0] busWdata,
  input  strobeT            stb,
  output logic [DATA_W-1:0] busRdata,
  output logic [NUM_W-1:0]  irqNum,
  output logic [VEC_W-1:0]  levelQ,
  output logic [VEC_W-1:0]  pendQ,
  output logic [VEC_W-1:0]  forceQ,
  output logic [VEC_W-1:0]  bcastQ,
  output logic [VEC_W-1:0]  maskQ
);
  logic [VEC_W-1:0] prevQ;
  logic [VEC_W-1:0] rise;
  logic [VEC_W-1:0] wLow;
  logic [VEC_W-1:0] wClr;
  logic [VEC_W-1:0] clrVec;
  logic [VEC_W-1:0] forceBase;
  logic [VEC_W-1:0] forceN;
  logic [VEC_W-1:0] pendN;
  logic [VEC_W-1:0] elig;
  logic [VEC_W-1:0] hiGrp;
  logic [VEC_W-1:0] served;
  logic unusedOk;

  assign unusedOk = busWdata[CLR_SHIFT];
  assign wLow     = busWdata[VEC_W-1:0] & LINE_MASK;
  assign wClr     = {busWdata[CLR_SHIFT+LINES:CLR_SHIFT+1], 1'b0};
  assign rise     = irqIn & ~prevQ & LINE_MASK;
  assign clrVec   = ((stb.wrClear ? wLow : '0) | stb.ackVec) & LINE_MASK;

  always_comb begin
    if (stb.wrForce)         forceBase = wLow;
    else if (stb.wrForceMod) forceBase = (forceQ | wLow) & ~wClr;
    else                     forceBase = forceQ;
  end

  // a fresh edge beats a same-cycle clear or acknowledge
  assign forceN = (forceBase & ~clrVec) | (rise & bcastQ);
  assign pendN  = (pendQ & ~clrVec) | (rise & ~bcastQ);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prevQ  <= '0;
      levelQ <= '0;
      pendQ  <= '0;
      forceQ <= '0;
      bcastQ <= '0;
      maskQ  <= '0;
    end else begin
      prevQ  <= irqIn;
      pendQ  <= pendN;
      forceQ <= forceN;
      if (stb.wrLevel) levelQ <= wLow;
      if (stb.wrBcast) bcastQ <= wLow;
      if (stb.wrMask)  maskQ  <= wLow;
    end
  end

  function automatic logic [NUM_W-1:0] topLine(input logic [VEC_W-1:0] v);
    logic [NUM_W-1:0] n;
    n = '0;
    for (int i = 1; i < VEC_W; i++) begin
      if (v[i]) n = NUM_W'(i);
    end
    return n;
  endfunction

  assign elig   = (pendQ | forceQ) & maskQ & LINE_MASK;
  assign hiGrp  = elig & levelQ;
  assign served = (|hiGrp) ? hiGrp : elig;
  assign irqNum = topLine(served);

  always_comb begin
    case (stb.rdSel)
      RD_LEVEL: busRdata = DATA_W'(levelQ);
      RD_PEND:  busRdata = DATA_W'(pendQ);
      RD_FORCE: busRdata = DATA_W'(forceQ);
      RD_BCAST: busRdata = DATA_W'(bcastQ);
      RD_MASK:  busRdata = DATA_W'(maskQ);
      default:  busRdata = '0;
    endcase
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import prio_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [VEC_W-1:0]  irqIn,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              ackValid,
  input  logic [NUM_W-1:0]  ackNum,
  output logic [NUM_W-1:0]  irqNum
);
  strobeT stb;
  logic [VEC_W-1:0] levelQ;
  logic [VEC_W-1:0] pendQ;
  logic [VEC_W-1:0] forceQ;
  logic [VEC_W-1:0] bcastQ;
  logic [VEC_W-1:0] maskQ;

  prio_irq_ctrl_ctl uCtl (
    .busSel   (busSel),
    .busWr    (busWr),
    .busAddr  (busAddr),
    .ackValid (ackValid),
    .ackNum   (ackNum),
    .stb      (stb)
  );

  prio_irq_ctrl_dp uDp (
    .clk      (clk),
    .rst_n    (rst_n),
    .irqIn    (irqIn),
    .busWdata (busWdata),
    .stb      (stb),
    .busRdata (busRdata),
    .irqNum   (irqNum),
    .levelQ   (levelQ),
    .pendQ    (pendQ),
    .forceQ   (forceQ),
    .bcastQ   (bcastQ),
    .maskQ    (maskQ)
  );
endmodule

// File: rtl/prio_irq_ctrl_chk.sv
module prio_irq_ctrl_chk
  import prio_irq_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [VEC_W-1:0]  irqIn,
  input logic              busSel,
  input logic              busWr,
  input logic [ADDR_W-1:0] busAddr,
  input logic [DATA_W-1:0] busRdata,
  input logic              ackValid,
  input logic [NUM_W-1:0]  ackNum,
  input logic [NUM_W-1:0]  irqNum,
  input logic [VEC_W-1:0]  levelQ,
  input logic [VEC_W-1:0]  pendQ,
  input logic [VEC_W-1:0]  forceQ,
  input logic [VEC_W-1:0]  maskQ
);
  logic [VEC_W-1:0] eligC;
  assign eligC = (pendQ | forceQ) & maskQ;

  assert_grant_eligible_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (irqNum != '0) |-> eligC[irqNum]);

  assert_no_request_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (eligC == '0) |-> (irqNum == '0));

  assert_high_group_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((eligC & levelQ) != '0) |-> levelQ[irqNum]);

  assert_ack_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ackValid && ackNum != '0 && !irqIn[ackNum] && !(busSel && busWr))
    |=> (!pendQ[$past(ackNum)] && !forceQ[$past(ackNum)]));

  assert_clear_reads_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busSel && !busWr && busAddr == OFF_CLEAR) |-> (busRdata == '0));
endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk uChk (
  .clk      (clk),
  .rst_n    (rst_n),
  .irqIn    (irqIn),
  .busSel   (busSel),
  .busWr    (busWr),
  .busAddr  (busAddr),
  .busRdata (busRdata),
  .ackValid (ackValid),
  .ackNum   (ackNum),
  .irqNum   (irqNum),
  .levelQ   (levelQ),
  .pendQ    (pendQ),
  .forceQ   (forceQ),
  .maskQ    (maskQ)
);

// File: tb/prio_irq_ctrl_test.sv
module prio_irq_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] irqIn = '0;
  logic        busSel = 1'b0;
  logic        busWr = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        ackValid = 1'b0;
  logic [3:0]  ackNum = '0;
  logic [3:0]  irqNum;

  int checkCnt = 0;
  int failCnt = 0;

  always #2 clk = ~clk;

  prio_irq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .irqIn(irqIn), .busSel(busSel), .busWr(busWr),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .ackValid(ackValid), .ackNum(ackNum), .irqNum(irqNum)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checkCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b0; busWdata = '0;
  endtask

  task automatic busRead(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b0; busAddr = a;
    #1 d = busRdata;
    busSel = 1'b0;
  endtask

  task automatic setLine(input int n, input logic v);
    @(negedge clk);
    irqIn[n] = v;
    @(negedge clk);
  endtask

  task automatic doAck(input logic [3:0] n);
    @(negedge clk);
    ackValid = 1'b1; ackNum = n;
    @(negedge clk);
    ackValid = 1'b0;
  endtask

  task automatic expRead(input string req, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] d;
    busRead(a, d);
    check(req, d, exp);
  endtask

  task automatic expNum(input string req, input logic [3:0] exp);
    @(negedge clk);
    #1 check(req, {28'd0, irqNum}, {28'd0, exp});
  endtask

  task automatic clearAll();
    busWrite(8'h0C, 32'hFFFF);
  endtask

  task automatic tReset();
    expRead("R1 level", 8'h00, 0);
    expRead("R1 pending", 8'h04, 0);
    expRead("R1 force", 8'h08, 0);
    expRead("R1 bcast", 8'h14, 0);
    expRead("R1 mask", 8'h40, 0);
    expNum("R1 irqNum", 0);
  endtask

  task automatic tReadback();
    busWrite(8'h00, 32'hFFFF_FFFF);
    expRead("R12 R10 level", 8'h00, 32'hFFFE);
    busWrite(8'h00, 32'h0);
    busWrite(8'h14, 32'h0000_A5A5);
    expRead("R12 R10 bcast", 8'h14, 32'hA5A4);
    busWrite(8'h14, 32'h0);
    busWrite(8'h40, 32'hFFFF_FFFF);
    expRead("R12 R10 mask", 8'h40, 32'hFFFE);
  endtask

  task automatic tPending();
    setLine(3, 1'b1);
    expRead("R2 pend line3", 8'h04, 32'h0008);
    expNum("R4 single line", 3);
    setLine(7, 1'b1);
    expNum("R4 highest wins", 7);
    setLine(3, 1'b0);
    expRead("R2 drop no effect", 8'h04, 32'h0088);
    repeat (3) @(negedge clk);
    doAck(4'd7);
    expRead("R8 ack 7 held high", 8'h04, 32'h0008);
    expNum("R4 after ack", 3);
    doAck(4'd0);
    expRead("R8 ack 0", 8'h04, 32'h0008);
    setLine(7, 1'b0);
    busWrite(8'h0C, 32'h0009);
    expRead("R7 R10 clear", 8'h04, 32'h0);
    expRead("R7 clear reads zero", 8'h0C, 32'h0);
    expNum("R4 none", 0);
  endtask

  task automatic tMask();
    setLine(5, 1'b1);
    setLine(5, 1'b0);
    busWrite(8'h40, 32'h0);
    expNum("R4 masked", 0);
    expRead("R4 masked kept pending", 8'h04, 32'h0020);
    busWrite(8'h40, 32'hFFFE);
    expNum("R4 unmasked", 5);
    clearAll();
  endtask

  task automatic tLevel();
    setLine(4, 1'b1);
    setLine(9, 1'b1);
    setLine(4, 1'b0);
    setLine(9, 1'b0);
    expNum("R5 low group only", 9);
    busWrite(8'h00, 32'h0010);
    expNum("R5 high group wins", 4);
    doAck(4'd4);
    expNum("R5 high empty", 9);
    busWrite(8'h00, 32'h0);
    clearAll();
  endtask

  task automatic tForce();
    busWrite(8'h08, 32'h0000_00F1);
    expRead("R6 R10 force write", 8'h08, 32'h00F0);
    busWrite(8'h80, 32'h0030_0103);
    expRead("R6 set/clear", 8'h08, 32'h01C2);
    expRead("R6 modify readback", 8'h80, 32'h01C2);
    expNum("R4 force path", 8);
    busWrite(8'h0C, 32'h0100);
    expRead("R7 clear force", 8'h08, 32'h00C2);
    doAck(4'd7);
    expRead("R8 ack force", 8'h08, 32'h0042);
    clearAll();
  endtask

  task automatic tBcast();
    busWrite(8'h14, 32'h0404);
    setLine(2, 1'b1);
    setLine(2, 1'b0);
    expRead("R3 force set", 8'h08, 32'h0004);
    expRead("R3 pend untouched", 8'h04, 32'h0);
    setLine(10, 1'b1);
    setLine(10, 1'b0);
    expRead("R3 force both", 8'h08, 32'h0404);
    expNum("R3 served", 10);
    busWrite(8'h14, 32'h0);
    clearAll();
  endtask

  task automatic tReadOnly();
    setLine(6, 1'b1);
    setLine(6, 1'b0);
    busWrite(8'h04, 32'hFFFF);
    expRead("R9 pend write ignored", 8'h04, 32'h0040);
    busWrite(8'h10, 32'hFFFF);
    expRead("R9 status zero", 8'h10, 32'h0);
    expRead("R9 unmapped", 8'h20, 32'h0);
    expRead("R9 misaligned", 8'h41, 32'h0);
    busWrite(8'h41, 32'h0);
    expRead("R9 misaligned write ignored", 8'h40, 32'hFFFE);
    clearAll();
  endtask

  task automatic tRace();
    setLine(6, 1'b1);
    setLine(6, 1'b0);
    @(negedge clk);
    irqIn[6] = 1'b1; ackValid = 1'b1; ackNum = 4'd6;
    @(negedge clk);
    ackValid = 1'b0;
    expRead("R11 edge beats ack", 8'h04, 32'h0040);
    setLine(6, 1'b0);
    @(negedge clk);
    irqIn[6] = 1'b1;
    busSel = 1'b1; busWr = 1'b1; busAddr = 8'h0C; busWdata = 32'h0040;
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b0; busWdata = '0;
    expRead("R11 edge beats clear", 8'h04, 32'h0040);
    setLine(6, 1'b0);
    clearAll();
  endtask

  initial begin
    #400000;
    checkCnt++;
    failCnt++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checkCnt, failCnt);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tReset();
    tReadback();
    tPending();
    tMask();
    tLevel();
    tForce();
    tBcast();
    tReadOnly();
    tRace();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checkCnt, failCnt);
    $finish;
  end
endmodule